// File: doc/BRIEF.md
# Decrementer Countdown Timer

This block holds a 32-bit count that moves down by one on every cycle in which its tick enable is high. Software may load the count at any time through a write port and read it back through a read port. When a decrement step takes the count from zero to all-ones, the block raises a sticky pending exception. The exception is presented as a request only while the external-enable mask from the processor status is set. While the mask is clear, the exception stays pending and is not lost.

The exception unit acknowledges a request that it has taken, and the acknowledge clears the pending flag. Together with the request, the block drives the handler vector offset, 0x900. The exception unit then saves the address of the next instruction, as for any other asynchronous interrupt. The tick source, the rest of exception arbitration and the handler software all lie outside this block. Reset is asynchronous on assertion, and its release is synchronised to the clock inside the block.

Top module: `dec_timer`

## Requirements
- R1: While reset is held, and in the first cycle after its synchronised release, rd_data is 0 and irq_req is 0.
- R2: A cycle with wr_en high loads wr_data into the count, and rd_data shows it after that clock edge.
- R3: With wr_en low, a cycle with tick_en high lowers the count by exactly one modulo 2^32. A cycle with tick_en low leaves the count unchanged.
- R4: When wr_en and tick_en are both high, the written value is loaded and no decrement happens in that cycle.
- R5: A decrement step from 0x0000_0000 to 0xFFFF_FFFF sets the pending exception from the next clock edge.
- R6: A software write never sets the pending exception, even when bit 31 of the written value is 1. A decrement from 0x8000_0000 to 0x7FFF_FFFF also leaves it clear.
- R7: irq_req equals pending AND ee_mask in the same cycle. With ee_mask low, the pending state is kept and appears as soon as ee_mask rises.
- R8: A cycle with ack high and no zero crossing clears the pending exception from the next edge.
- R9: If ack and a zero crossing happen in the same cycle, the pending exception is set after that edge.
- R10: irq_vec is 12'h900 while irq_req is high and 0 otherwise.
- R11: Once set, the pending exception stays set across further ticks and writes until an acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Software write strobe for the count |
| wr_data | input | 32 | Value loaded into the count on a write |
| rd_data | output | 32 | Current count |
| tick_en | input | 1 | Decrement enable for this cycle |
| ee_mask | input | 1 | External-enable mask from processor status |
| ack | input | 1 | Acknowledge from the exception unit, clears pending |
| irq_req | output | 1 | Exception request, pending gated by the mask |
| irq_vec | output | 12 | Vector offset, 0x900 while requesting |

## Verification
A wrong count shows on rd_data one edge after the write or tick that produced it. Each step is compared against a model of the count, so an off-by-one or a missed override is visible at once. A pending flag that is set or cleared wrongly shows on irq_req in the very next cycle when ee_mask is high. When the mask is low, the fault stays hidden until the mask rises, so the bench checks the flag with the mask both low and high. The corner cases are the ones a correct count does not reveal: a zero crossing with an acknowledge in the same cycle, a write of a value with the top bit set, and the fall of the top bit.

// File: rtl/dec_timer_pkg.sv
package dec_timer_pkg;

  // Operation applied to the count in a given cycle
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/dec_rst_sync.sv
module dec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dec_counter.sv
module dec_counter
  import dec_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         tick_en,
  output logic [W-1:0] cnt_q,
  output logic         wrap_o
);

  localparam int MSB = W - 1;

  cnt_op_e      op;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // Selects the operation; a software write wins over a tick
  always_comb begin
    if (wr_en) begin
      op = CNT_LOAD;
    end else if (tick_en) begin
      op = CNT_DEC;
    end else begin
      op = CNT_HOLD;
    end
  end

  always_comb begin
    unique case (op)
      CNT_LOAD: cnt_d = wr_data;
      CNT_DEC:  cnt_d = cnt_q - {{(W-1){1'b0}}, 1'b1};
      default:  cnt_d = cnt_q;
    endcase
  end

  assign cnt_en = (op != CNT_HOLD);

  // A zero crossing is a decrement step on which the top bit rises
  assign wrap_o = (op == CNT_DEC) && !cnt_q[MSB] && cnt_d[MSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dec_pending.sv
module dec_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_q
);

  logic pend_d;
  logic pend_en;

  // Setting has priority over clearing
  always_comb begin
    if (set_i) begin
      pend_d = 1'b1;
    end else if (clr_i) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  assign pend_en = set_i | clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/dec_timer.sv
module dec_timer #(
  parameter int               W          = 32,
  parameter int               VEC_W      = 12,
  parameter logic [VEC_W-1:0] VEC_OFFSET = 12'h900,
  parameter int               RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     rd_data,
  input  logic             tick_en,
  input  logic             ee_mask,
  input  logic             ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);

  logic         rst_sync_n;
  logic [W-1:0] cnt_q;
  logic         wrap_evt;
  logic         pend_q;

  dec_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dec_counter #(.W(W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tick_en (tick_en),
    .cnt_q   (cnt_q),
    .wrap_o  (wrap_evt)
  );

  dec_pending u_pending (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (wrap_evt),
    .clr_i  (ack),
    .pend_q (pend_q)
  );

  assign rd_data = cnt_q;
  assign irq_req = pend_q & ee_mask;
  assign irq_vec = irq_req ? VEC_OFFSET : '0;

endmodule

// File: rtl/dec_timer_chk.sv
module dec_timer_chk #(
  parameter int               W          = 32,
  parameter int               VEC_W      = 12,
  parameter logic [VEC_W-1:0] VEC_OFFSET = 12'h900
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [W-1:0]     wr_data,
  input logic             tick_en,
  input logic             ee_mask,
  input logic             ack,
  input logic [W-1:0]     rd_data,
  input logic             pend_q,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec
);

  logic step_dec;
  logic at_zero_dec;

  assign step_dec    = tick_en && !wr_en;
  assign at_zero_dec = step_dec && (rd_data == '0);

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  assert_tick_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_dec |=> rd_data == $past(rd_data) - 1);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> $stable(rd_data));

  assert_wrap_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero_dec |=> pend_q);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !at_zero_dec) |=> !pend_q);

  assert_mask_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_mask |-> !irq_req);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !at_zero_dec) |=> !pend_q);

  assert_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec == VEC_OFFSET);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q);

endmodule

bind dec_timer dec_timer_chk #(
  .W          (W),
  .VEC_W      (VEC_W),
  .VEC_OFFSET (VEC_OFFSET)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .tick_en (tick_en),
  .ee_mask (ee_mask),
  .ack     (ack),
  .rd_data (rd_data),
  .pend_q  (pend_q),
  .irq_req (irq_req),
  .irq_vec (irq_vec)
);

// File: tb/dec_timer_tb.sv
`timescale 1ns/1ps
module dec_timer_tb;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        tick_en;
  logic        ee_mask;
  logic        ack;
  logic        irq_req;
  logic [11:0] irq_vec;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] cnt;
    logic        req;
    logic [11:0] vec;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  logic [31:0] m_cnt;
  logic        m_pend;
  logic        done;

  dec_timer u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tick_en (tick_en),
    .ee_mask (ee_mask),
    .ack     (ack),
    .irq_req (irq_req),
    .irq_vec (irq_vec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the result expected after the edge
  task automatic step(input logic w, input logic [31:0] d, input logic t,
                      input logic e, input logic a, input string tag);
    exp_t  item;
    logic  wrap;
    @(negedge clk);
    wr_en = w; wr_data = d; tick_en = t; ee_mask = e; ack = a;
    wrap = !w && t && (m_cnt == 32'h0);
    if (w) m_cnt = d;
    else if (t) m_cnt = m_cnt - 32'd1;
    if (wrap) m_pend = 1'b1;
    else if (a) m_pend = 1'b0;
    item.cnt = m_cnt;
    item.req = m_pend && e;
    item.vec = item.req ? 12'h900 : 12'h000;
    item.tag = tag;
    exp_q.push_back(item);
  endtask

  // Monitor: samples just after each edge, while inputs are still those of the step
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check({it.tag, " count"}, rd_data, it.cnt);
        check({it.tag, " req"}, {31'd0, irq_req}, {31'd0, it.req});
        check({it.tag, " vec"}, {20'd0, irq_vec}, {20'd0, it.vec});
      end
    end
  end

  // Watchdog
  initial begin
    done = 1'b0;
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tick_en = 1'b0; ee_mask = 1'b0; ack = 1'b0;
    m_cnt = '0; m_pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset count", rd_data, 32'h0);
    check("R1 in reset req", {31'd0, irq_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check("R1 after release count", rd_data, 32'h0);
    check("R1 after release req", {31'd0, irq_req}, 32'h0);

    step(1, 32'd5, 0, 1, 0, "R2 load");
    step(0, 32'd0, 1, 1, 0, "R3 tick");
    step(0, 32'd0, 1, 1, 0, "R3 tick");
    step(0, 32'd0, 0, 1, 0, "R3 hold");
    step(0, 32'd0, 1, 1, 0, "R3 tick");
    step(1, 32'd10, 1, 1, 0, "R4 write over tick");
    step(0, 32'd0, 0, 1, 0, "R4 hold after write");

    step(1, 32'd1, 0, 0, 0, "R2 load one");
    step(0, 32'd0, 1, 0, 0, "R3 tick to zero");
    step(0, 32'd0, 1, 0, 0, "R5 R7 wrap masked");
    step(0, 32'd0, 1, 0, 0, "R7 still masked");
    step(0, 32'd0, 0, 1, 0, "R7 R10 unmask");
    step(0, 32'd0, 1, 1, 0, "R11 sticky tick");
    step(1, 32'd42, 0, 1, 0, "R11 sticky write");
    step(0, 32'd0, 0, 1, 1, "R8 ack clears");
    step(0, 32'd0, 0, 1, 0, "R8 stays clear");

    step(1, 32'h8000_0000, 0, 1, 0, "R6 write msb set");
    step(0, 32'd0, 0, 1, 0, "R6 no pending after write");
    step(0, 32'd0, 1, 1, 0, "R6 msb falls");
    step(1, 32'hFFFF_FFFF, 0, 1, 0, "R6 write all ones");

    step(1, 32'd1, 0, 1, 0, "R2 load one again");
    step(0, 32'd0, 1, 1, 0, "R3 tick to zero again");
    step(0, 32'd0, 1, 1, 1, "R9 wrap with ack");
    step(0, 32'd0, 0, 1, 0, "R9 pending kept");
    step(1, 32'd0, 1, 1, 1, "R8 ack with write no wrap");
    step(0, 32'd0, 1, 0, 0, "R5 wrap from written zero");
    step(0, 32'd0, 1, 1, 0, "R7 R10 request seen");
    step(0, 32'd0, 0, 0, 1, "R8 ack masked");
    step(0, 32'd0, 0, 1, 0, "R8 clear when unmasked");

    for (int i = 0; i < 6; i++) begin
      step(i == 0, 32'd3, 1'b1, i[0], 1'b0, "R3 R5 run");
    end
    step(0, 32'd0, 0, 0, 0, "idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule